// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a serial slave that gives a host processor access to a small register file over a four-wire SPI link. The link has a chip select, a serial clock, a data input and a data output. The slave does not hold the registers itself. It turns each SPI frame into single-cycle read and write strobes on a simple parallel register bus, and the register file sits behind that bus. The bus serves an eleven-entry register file with addresses 0x00 to 0x0A.

A frame starts when chip select goes low and ends when it returns high. The first byte is an opcode. It carries a fixed device prefix, two device-select bits and a read/write flag. The second byte loads the register pointer. Every byte after that either writes the register under the pointer or returns its contents on the data output. The pointer then moves to the next register and wraps to 0x00. Software can instead freeze the pointer, so that one register is polled or written again and again. A second configuration input makes the slave compare the two device-select bits against its strap pins. With that check on, several slaves can share one chip select.

The link runs in SPI mode 0. The slave samples the data input on the rising clock edge and changes the data output on the falling edge. All SPI pins are brought into the system clock domain through synchronizers, so the serial clock must be a good deal slower than the system clock.

The controller has six states:
- IDLE: chip select is high.
- OPCODE: the first byte is being shifted in.
- ADDR: the pointer byte is being shifted in.
- WDATA: data bytes are being written.
- RDATA: data bytes are being read out.
- SKIP: the opcode did not match, and the rest of the frame is ignored.

The transitions are:
- IDLE to OPCODE, when chip select is seen low.
- OPCODE to ADDR, on a matching opcode byte.
- OPCODE to SKIP, on an opcode that does not match.
- ADDR to WDATA or to RDATA, by the read/write flag.
- WDATA and RDATA loop on themselves, one register per byte.
- Any state to IDLE, when chip select is seen high.

Top module: `spi_regbus_slave`

## Requirements
- R1: After reset, the write strobe, the read strobe and the data-output enable are all low.
- R2: The opcode byte is bits [7:3] = 01000, bits [2:1] = device-select, bit [0] = 1 for read and 0 for write. Bytes are shifted in MSB first on rising SCK edges. In a write frame, the byte after the opcode sets the pointer and the next byte is written to that register.
- R3: In a read frame, the register addressed by the second byte is shifted out MSB first on SO. Its first bit is valid before the first rising SCK edge of the data phase, and later bits change on falling edges.
- R4: When the pointer is not frozen, it advances by one after each data byte. From 0x0A or any higher value it moves to 0x00.
- R5: With cfg_ptr_hold = 1, every data byte of the frame writes, or returns, the same register.
- R6: An opcode whose bits [7:3] are not 01000 causes no write strobe and no output enable for the rest of the frame.
- R7: With cfg_id_check = 1, an opcode whose bits [2:1] differ from strap_id is ignored for the rest of the frame. With cfg_id_check = 0, those bits are not compared.
- R8: spi_so_oe is high only while chip select is low and the frame is in its read-data phase. It is low during the opcode and pointer bytes, during write frames and while chip select is high.
- R9: A byte cut off by chip select rising before its eighth rising SCK edge is dropped. A byte whose eighth rising edge comes before chip select rises is still written. The next frame starts again with an opcode byte.
- R10: The write and read strobes each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, idles low (mode 0) |
| spi_si | input | 1 | SPI data from the host |
| spi_so | output | 1 | SPI data to the host |
| spi_so_oe | output | 1 | Drive enable for the SO pad driver |
| strap_id | input | STRAP_W | Device-select strap pins |
| cfg_id_check | input | 1 | 1: compare opcode bits [2:1] against strap_id |
| cfg_ptr_hold | input | 1 | 1: pointer does not advance between data bytes |
| bus_addr | output | 8 | Register bus address |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rd | output | 1 | One-cycle read strobe; bus_rdata is taken in the same cycle |
| bus_rdata | input | 8 | Read data from the register file |

## Verification
Two events can meet in the same cycle. The first is the completion of a byte by its eighth rising SCK edge. The second is the end of the frame when chip select rises. The bench provokes this by raising chip select one system clock after that eighth edge, before SCK falls. Both then arrive through the synchronizer almost together. The bench judges the result at the register file: the completed byte must land in its register. A second test cuts a byte after five bits. That byte must leave the register file untouched, and the next frame must decode its first byte as an opcode.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } rb_state_t;
endpackage

// File: rtl/spi_rb_sync.sv
// Brings the three SPI inputs into the clk domain and finds SCK edges.
module spi_rb_sync #(
    parameter int STAGES = 2            // must be 2 or more
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    input  logic sck_raw,
    input  logic si_raw,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    localparam int LINES = 3;
    localparam logic [LINES-1:0] IDLE_VAL = 3'b001;  // chip select idles high

    logic [LINES-1:0] raw_vec;
    logic [LINES-1:0] synced;
    logic             sck_d;

    assign raw_vec = {si_raw, sck_raw, cs_n_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{IDLE_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], raw_vec[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= synced[1];
    end

    assign cs_act   = !synced[0];
    assign sck_rise = cs_act && synced[1] && !sck_d;
    assign sck_fall = cs_act && !synced[1] && sck_d;
    assign si_s     = synced[2];
endmodule

// File: rtl/spi_rb_shifter.sv
// Bit counter, receive shifter and transmit shifter for one byte lane.
module spi_rb_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_on,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         si_s,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         byte_done,
    output logic [W-1:0] rx_byte,
    output logic         so_bit
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  rx_sh;
    logic [W-1:0]  tx_sh;

    // receive side: a partial byte is dropped whenever the frame closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!frame_on) begin
                cnt   <= '0;
                rx_sh <= '0;
            end else if (sck_rise) begin
                rx_sh <= {rx_sh[W-2:0], si_s};
                cnt   <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
                if (cnt == LAST_BIT) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh[W-2:0], si_s};
                end
            end
        end
    end

    // transmit side: MSB waits on the line; falls inside a byte move it on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_data;
        end else if (frame_on && sck_fall && cnt != '0) begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
    end

    assign so_bit = tx_sh[W-1];

    AST_FRAME_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_on) |-> (cnt == '0)); // R9
    AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R10
endmodule

// File: rtl/spi_rb_ctrl.sv
// Frame sequencer: opcode check, pointer handling and register bus strobes.
module spi_rb_ctrl
    import spi_rb_pkg::*;
#(
    parameter int W        = 8,
    parameter int STRAP_W  = 2,
    parameter int PREFIX_W = W - STRAP_W - 1,
    parameter logic [PREFIX_W-1:0] PREFIX = 'b01000,
    parameter int LAST_REG = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               byte_done,
    input  logic [W-1:0]       rx_byte,
    input  logic [STRAP_W-1:0] strap,
    input  logic               id_check,
    input  logic               ptr_hold,
    output logic [W-1:0]       bus_addr,
    output logic               bus_wr,
    output logic [W-1:0]       bus_wdata,
    output logic               bus_rd,
    output logic               rd_active
);
    localparam int STRAP_LSB = 1;
    localparam logic [W-1:0] LAST_PTR = W'(LAST_REG);

    rb_state_t    state, state_nx;
    logic         rw_rd;
    logic [W-1:0] ptr;
    logic [W-1:0] ptr_nx;
    logic         id_ok;

    assign id_ok = (rx_byte[W-1 -: PREFIX_W] == PREFIX) &&
                   (!id_check || rx_byte[STRAP_LSB +: STRAP_W] == strap);

    assign ptr_nx = ptr_hold          ? ptr :
                    (ptr >= LAST_PTR) ? '0  : ptr + W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!cs_act) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_OPCODE;
                ST_OPCODE: if (byte_done) state_nx = id_ok ? ST_ADDR : ST_SKIP;
                ST_ADDR:   if (byte_done) state_nx = rw_rd ? ST_RDATA : ST_WDATA;
                ST_WDATA:  state_nx = ST_WDATA;
                ST_RDATA:  state_nx = ST_RDATA;
                ST_SKIP:   state_nx = ST_SKIP;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_rd     <= 1'b0;
            ptr       <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            if (byte_done) begin
                if (state == ST_OPCODE) begin
                    rw_rd <= rx_byte[0];
                end else if (state == ST_ADDR) begin
                    ptr <= rx_byte;
                    if (rw_rd) begin
                        bus_rd   <= 1'b1;
                        bus_addr <= rx_byte;
                    end
                end else if (state == ST_WDATA) begin
                    bus_wr    <= 1'b1;
                    bus_addr  <= ptr;
                    bus_wdata <= rx_byte;
                    ptr       <= ptr_nx;
                end else if (state == ST_RDATA) begin
                    bus_rd   <= 1'b1;
                    bus_addr <= ptr_nx;
                    ptr      <= ptr_nx;
                end
            end
        end
    end

    assign rd_active = (state == ST_RDATA);

    AST_WR_FROM_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ($past(state) == ST_WDATA)); // R2
    AST_OE_ONLY_READ_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> rw_rd); // R8
    AST_SKIP_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!bus_wr && !bus_rd)); // R6
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr); // R10
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
    import spi_rb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LAST_REG    = 10,
    parameter int STRAP_W     = 2,
    parameter logic [BYTE_W-STRAP_W-2:0] DEV_PREFIX = 'b01000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_cs_n,
    input  logic               spi_sck,
    input  logic               spi_si,
    output logic               spi_so,
    output logic               spi_so_oe,
    input  logic [STRAP_W-1:0] strap_id,
    input  logic               cfg_id_check,
    input  logic               cfg_ptr_hold,
    output logic [BYTE_W-1:0]  bus_addr,
    output logic               bus_wr,
    output logic [BYTE_W-1:0]  bus_wdata,
    output logic               bus_rd,
    input  logic [BYTE_W-1:0]  bus_rdata
);
    localparam int PREFIX_W = BYTE_W - STRAP_W - 1;

    logic              cs_act;
    logic              sck_rise;
    logic              sck_fall;
    logic              si_s;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              rd_active;

    spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_raw (spi_cs_n),
        .sck_raw  (spi_sck),
        .si_raw   (spi_si),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    spi_rb_shifter #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_on  (cs_act),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .si_s      (si_s),
        .load      (bus_rd),
        .load_data (bus_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .so_bit    (spi_so)
    );

    spi_rb_ctrl #(
        .W        (BYTE_W),
        .STRAP_W  (STRAP_W),
        .PREFIX_W (PREFIX_W),
        .PREFIX   (DEV_PREFIX),
        .LAST_REG (LAST_REG)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .strap     (strap_id),
        .id_check  (cfg_id_check),
        .ptr_hold  (cfg_ptr_hold),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .rd_active (rd_active)
    );

    // raw chip select gates the pad so it releases without synchronizer lag
    assign spi_so_oe = !spi_cs_n && rd_active;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R10
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd); // R10
endmodule

// File: tb/sim_spi_regbus_slave.sv
module sim_spi_regbus_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic [1:0] strap = 2'b00;
    logic       id_chk = 1'b0, hold = 1'b0;
    wire        so, so_oe, bwr, brd;
    wire [7:0]  baddr, bwdata;
    logic [7:0] brdata;
    logic [7:0] mem [11];

    spi_regbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .strap_id(strap), .cfg_id_check(id_chk),
        .cfg_ptr_hold(hold), .bus_addr(baddr), .bus_wr(bwr), .bus_wdata(bwdata),
        .bus_rd(brd), .bus_rdata(brdata)
    );

    // register file behind the bus
    always_comb brdata = (baddr < 8'd11) ? mem[baddr[3:0]] : 8'h00;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 11; i++) mem[i] <= 8'h00;
        end else if (bwr && baddr < 8'd11) begin
            mem[baddr[3:0]] <= bwdata;
        end
    end

    int n_wr = 0, n_clash = 0, n_long = 0;
    logic bwr_q = 1'b0, brd_q = 1'b0;
    always @(negedge clk) begin
        if (bwr) n_wr++;
        if (bwr && brd) n_clash++;
        if ((bwr && bwr_q) || (brd && brd_q)) n_long++;
        bwr_q = bwr;
        brd_q = brd;
    end

    int n_run = 0, n_fail = 0;
    bit done = 0;
    localparam int HB = 8;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] opc(input logic [1:0] id, input bit rd);
        return {5'b01000, id, rd};
    endfunction

    task automatic spi_open();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HB);
    endtask

    task automatic spi_close();
        wait_clk(HB);
        cs_n = 1'b1;
        wait_clk(HB);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            si = tx[i];
            wait_clk(HB);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(HB);
            sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic wr_frame(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d);
        logic [7:0] rx;
        spi_open();
        spi_byte(op, rx);
        spi_byte(a, rx);
        spi_byte(d, rx);
        spi_close();
    endtask

    task automatic t_reset();
        check_eq("R1", "write strobe after reset", int'(bwr), 0);
        check_eq("R1", "read strobe after reset", int'(brd), 0);
        check_eq("R1", "so enable after reset", int'(so_oe), 0);
    endtask

    task automatic t_write_single();
        logic [7:0] rx;
        spi_open();
        spi_byte(opc(2'b00, 0), rx);
        spi_byte(8'h03, rx);
        spi_byte(8'hA5, rx);
        check_eq("R8", "so enable in write frame", int'(so_oe), 0);
        spi_close();
        check_eq("R2", "reg3 written", int'(mem[3]), 'hA5);
        check_eq("R2", "reg2 untouched", int'(mem[2]), 0);
        check_eq("R2", "reg4 untouched", int'(mem[4]), 0);
    endtask

    task automatic t_read_single();
        logic [7:0] rx;
        wr_frame(opc(2'b00, 0), 8'h05, 8'h3C);
        spi_open();
        spi_byte(opc(2'b00, 1), rx);
        check_eq("R8", "so enable after opcode", int'(so_oe), 0);
        spi_byte(8'h05, rx);
        check_eq("R8", "so enable in read data phase", int'(so_oe), 1);
        spi_byte(8'hFF, rx);
        check_eq("R3", "read reg5", int'(rx), 'h3C);
        spi_close();
        check_eq("R8", "so enable after cs high", int'(so_oe), 0);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] rx;
        spi_open();
        spi_byte(opc(2'b00, 0), rx);
        spi_byte(8'h09, rx);
        spi_byte(8'h11, rx);
        spi_byte(8'h22, rx);
        spi_byte(8'h33, rx);
        spi_close();
        check_eq("R4", "seq write reg9", int'(mem[9]), 'h11);
        check_eq("R4", "seq write reg10", int'(mem[10]), 'h22);
        check_eq("R4", "seq write wraps to reg0", int'(mem[0]), 'h33);
        spi_open();
        spi_byte(opc(2'b00, 1), rx);
        spi_byte(8'h0A, rx);
        spi_byte(8'h00, rx);
        check_eq("R4", "seq read reg10", int'(rx), 'h22);
        spi_byte(8'h00, rx);
        check_eq("R4", "seq read wraps to reg0", int'(rx), 'h33);
        spi_byte(8'h00, rx);
        check_eq("R4", "seq read reg1", int'(rx), 'h00);
        spi_close();
        // pointer above the last register also wraps to 0x00
        spi_open();
        spi_byte(opc(2'b00, 0), rx);
        spi_byte(8'h0F, rx);
        spi_byte(8'hAA, rx);
        spi_byte(8'hBB, rx);
        spi_close();
        check_eq("R4", "out-of-range pointer wraps to reg0", int'(mem[0]), 'hBB);
    endtask

    task automatic t_hold();
        logic [7:0] rx;
        hold = 1'b1;
        spi_open();
        spi_byte(opc(2'b00, 0), rx);
        spi_byte(8'h02, rx);
        spi_byte(8'h44, rx);
        spi_byte(8'h55, rx);
        spi_close();
        check_eq("R5", "held write last byte in reg2", int'(mem[2]), 'h55);
        check_eq("R5", "reg3 not reached", int'(mem[3]), 'hA5);
        spi_open();
        spi_byte(opc(2'b00, 1), rx);
        spi_byte(8'h02, rx);
        for (int k = 0; k < 3; k++) begin
            spi_byte(8'h00, rx);
            check_eq("R5", "held read reg2", int'(rx), 'h55);
        end
        spi_close();
        hold = 1'b0;
    endtask

    task automatic t_bad_prefix();
        logic [7:0] rx;
        int wr0;
        wr0 = n_wr;
        wr_frame(8'h50, 8'h01, 8'h99);
        check_eq("R6", "bad prefix write reg1", int'(mem[1]), 0);
        check_eq("R6", "bad prefix write strobes", n_wr - wr0, 0);
        spi_open();
        spi_byte(8'h51, rx);
        spi_byte(8'h05, rx);
        check_eq("R6", "bad prefix read so enable", int'(so_oe), 0);
        spi_byte(8'h00, rx);
        check_eq("R6", "bad prefix read so enable later", int'(so_oe), 0);
        spi_close();
    endtask

    task automatic t_device_id();
        id_chk = 1'b1;
        strap  = 2'b10;
        wr_frame(opc(2'b10, 0), 8'h06, 8'h66);
        check_eq("R7", "matching id written", int'(mem[6]), 'h66);
        wr_frame(opc(2'b01, 0), 8'h07, 8'h77);
        check_eq("R7", "other id ignored", int'(mem[7]), 0);
        id_chk = 1'b0;
        wr_frame(opc(2'b01, 0), 8'h07, 8'h78);
        check_eq("R7", "id not compared when check off", int'(mem[7]), 'h78);
    endtask

    task automatic t_partial();
        logic [7:0] rx;
        spi_open();
        spi_byte(opc(2'b00, 0), rx);
        spi_byte(8'h04, rx);
        spi_byte(8'h12, rx);
        spi_bits(8'hF0, 5, rx);
        spi_close();
        check_eq("R9", "full byte before cut written", int'(mem[4]), 'h12);
        check_eq("R9", "cut byte dropped", int'(mem[5]), 'h3C);
        wr_frame(opc(2'b00, 0), 8'h08, 8'h5A);
        check_eq("R9", "next frame starts with opcode", int'(mem[8]), 'h5A);
    endtask

    task automatic t_edge_release();
        logic [7:0] rx;
        spi_open();
        spi_byte(opc(2'b00, 0), rx);
        spi_byte(8'h01, rx);
        spi_bits(8'hC3, 7, rx);
        si = 1'b1;
        wait_clk(HB);
        sck = 1'b1;
        wait_clk(1);
        cs_n = 1'b1;
        wait_clk(HB);
        sck = 1'b0;
        wait_clk(HB);
        check_eq("R9", "byte completed as cs rises", int'(mem[1]), 'hC3);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_single();
        t_read_single();
        t_seq_wrap();
        t_hold();
        t_bad_prefix();
        t_device_id();
        t_partial();
        t_edge_release();
        check_eq("R10", "strobes together", n_clash, 0);
        check_eq("R10", "strobes longer than one cycle", n_long, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule